// File: doc/BRIEF.md
# DMA Graceful Stop and Transmit Poll Controller

This block sits next to the control register of a DMA engine that moves frames in both directions. When software writes that register, the block decodes three fields: a request to stop receiving gracefully, a request to stop transmitting gracefully, and a bit that turns off transmit-descriptor polling. A stop request completes at once when its path is idle. When a frame is still moving on that path, completion is held back until the frame ends. Completion is signalled by a one-cycle event pulse for each direction.

The block also keeps a self-rearming poll timer. Each expiry asks the descriptor logic to walk transmit ring 0, unless a transmit stop is in force. The timer's period is one tick of a slow poll rate, derived from the system clock frequency. Any control write with polling enabled restarts the timer with a full period. An expiry that finds polling disabled stops the timer without re-arming it. The descriptor walk and the interrupt event registers live elsewhere. They consume this block's three pulses.

Top module: `dma_stop_poll_ctrl`

## Requirements
- R1: A control write with bit 4 (receive stop) set while `rx_busy` is low makes `rx_stop_done` high for exactly the one cycle after the write's clock edge.
- R2: A receive stop written while `rx_busy` is high raises no pulse until `rx_eof` is sampled high. `rx_stop_done` then pulses once, in the cycle after that edge. Later `rx_eof` strobes with nothing pending raise nothing.
- R3: A control write with bit 3 (transmit stop) set while `tx_busy` is low makes `tx_stop_done` high for exactly the one cycle after the write's clock edge. Both stop bits in one write give both pulses in the same cycle.
- R4: A transmit stop written while `tx_busy` is high is deferred to the cycle after `tx_eof` is sampled, and it fires there exactly once.
- R5: A control write with bit 6 (poll disable) clear restarts the poll timer. The next `ring0_poll` pulse comes PERIOD cycles after that write's edge, where PERIOD = CLK_HZ / POLL_HZ. A restart discards any partly elapsed period.
- R6: While the last written word has bits 6 and 3 clear, `ring0_poll` pulses for one cycle every PERIOD cycles.
- R7: While the last written word has bit 3 set, the timer keeps re-arming but `ring0_poll` stays low. Polls resume after a write that clears bit 3 and bit 6.
- R8: A control write with bit 6 set does not restart the timer. The next expiry stops the timer, and no `ring0_poll` pulse follows.
- R9: During and after reset all three outputs are low, no stop is pending, and the timer is idle until a write with bit 6 clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | CTL_W | Control write data (bit 3 transmit stop, bit 4 receive stop, bit 6 poll disable) |
| rx_busy | input | 1 | A receive frame is in progress |
| rx_eof | input | 1 | Receive frame end strobe |
| tx_busy | input | 1 | A transmit frame is in progress |
| tx_eof | input | 1 | Transmit frame end strobe |
| rx_stop_done | output | 1 | Receive graceful stop complete pulse |
| tx_stop_done | output | 1 | Transmit graceful stop complete pulse |
| ring0_poll | output | 1 | Request to walk transmit ring 0 |

## Verification
The stop logic is tried with each stop bit written while its path is idle, with both bits written together, and with each bit written while its frame is busy. The busy case is followed by a first and a second end-of-frame strobe, which separates the immediate, deferred and duplicated completions. The timer is tried with a single start, with a second start in the middle of a period, with a transmit stop in force, and with polling disabled. These patterns separate the restart, the re-arm, the suppression and the halt. Every expected pulse is scheduled for its exact cycle, and any pulse that was not scheduled is reported.

// File: rtl/dsp_pkg.sv
// Shared types for the graceful stop and poll controller.
// Assumes: one receive path and one transmit path.
package dsp_pkg;

    // Path indices used by the stop trackers
    localparam int unsigned PATH_RX = 0;
    localparam int unsigned PATH_TX = 1;
    localparam int unsigned N_PATHS = 2;

    // Fields decoded from one control write
    typedef struct packed {
        logic rx_stop;
        logic tx_stop;
        logic no_poll;
    } ctl_fields_t;

    // Fields the poll timer needs between writes
    typedef struct packed {
        logic tx_stop;
        logic no_poll;
    } timer_cfg_t;

endpackage

// File: rtl/dsp_ctl_decode.sv
// Decodes a control write into stop requests and a timer restart,
// and holds the fields the poll timer consults at expiry.
// Assumes: bit positions are distinct and below CTL_W.
module dsp_ctl_decode
    import dsp_pkg::*;
#(
    parameter int unsigned CTL_W      = 32,
    parameter int unsigned RXSTOP_BIT = 4,
    parameter int unsigned TXSTOP_BIT = 3,
    parameter int unsigned NOPOLL_BIT = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CTL_W-1:0] wdata,
    output logic             rx_req,
    output logic             tx_req,
    output logic             restart,
    output timer_cfg_t       cfg_q
);

    ctl_fields_t fields;
    logic        unused_wdata;

    // Pull the three fields out of the written word
    always_comb begin
        fields.rx_stop = wdata[RXSTOP_BIT];
        fields.tx_stop = wdata[TXSTOP_BIT];
        fields.no_poll = wdata[NOPOLL_BIT];
    end

    // Other bits of the word belong to logic outside this block
    assign unused_wdata = ^wdata;

    // Strobes that last only for the write cycle
    always_comb begin
        rx_req  = wr & fields.rx_stop;
        tx_req  = wr & fields.tx_stop;
        restart = wr & ~fields.no_poll;
    end

    // Keep the last written timer-related fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr) begin
            cfg_q.tx_stop <= fields.tx_stop;
            cfg_q.no_poll <= fields.no_poll;
        end
    end

endmodule

// File: rtl/dsp_stop_track.sv
// Tracks one graceful stop request for one direction. Completes at
// once when the path is idle, or at the next end-of-frame otherwise.
// Assumes: eof is a single-cycle strobe from the same clock domain.
module dsp_stop_track (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic busy,
    input  logic eof,
    output logic done,
    output logic pending
);

    logic fire;
    logic pend_d;

    // Decide whether completion happens in this cycle
    always_comb begin
        fire   = (pending & eof) | (req & ~busy);
        pend_d = (pending | (req & busy)) & ~fire;
    end

    // Register the pending flag and the completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            done    <= 1'b0;
        end else begin
            pending <= pend_d;
            done    <= fire;
        end
    end

endmodule

// File: rtl/dsp_poll_timer.sv
// Self-rearming transmit descriptor poll timer. A restart loads a full
// period. At expiry it polls ring 0 unless transmit stop is set, and
// re-arms unless polling is disabled.
// Assumes: PERIOD >= 2; restart takes precedence over a same-cycle expiry.
module dsp_poll_timer #(
    parameter int unsigned PERIOD = 1_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic no_poll,
    input  logic tx_stop,
    output logic poll
);

    localparam int unsigned CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(PERIOD - 1);

    typedef enum logic {T_IDLE, T_RUN} tstate_t;

    tstate_t       state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          poll_d;
    logic          expire;

    assign expire = (state_q == T_RUN) && (cnt_q == '0);

    // Next-state logic for the countdown
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        poll_d  = 1'b0;
        if (restart) begin
            state_d = T_RUN;
            cnt_d   = RELOAD;
        end else if (expire) begin
            if (no_poll) begin
                state_d = T_IDLE;
            end else begin
                poll_d = ~tx_stop;
                cnt_d  = RELOAD;
            end
        end else if (state_q == T_RUN) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    // Timer registers and the registered poll pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= T_IDLE;
            cnt_q   <= '0;
            poll    <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            poll    <= poll_d;
        end
    end

endmodule

// File: rtl/dma_stop_poll_ctrl.sv
// Top of the graceful stop and poll controller. Decodes control writes,
// runs one stop tracker per direction and the ring-0 poll timer.
// Assumes: CLK_HZ / POLL_HZ >= 2.
module dma_stop_poll_ctrl
    import dsp_pkg::*;
#(
    parameter int unsigned CTL_W      = 32,
    parameter int unsigned RXSTOP_BIT = 4,
    parameter int unsigned TXSTOP_BIT = 3,
    parameter int unsigned NOPOLL_BIT = 6,
    parameter int unsigned CLK_HZ     = 100_000_000,
    parameter int unsigned POLL_HZ    = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             rx_busy,
    input  logic             rx_eof,
    input  logic             tx_busy,
    input  logic             tx_eof,
    output logic             rx_stop_done,
    output logic             tx_stop_done,
    output logic             ring0_poll
);

    localparam int unsigned PERIOD = CLK_HZ / POLL_HZ;

    logic       rx_req, tx_req, restart;
    timer_cfg_t cfg_q;

    logic [N_PATHS-1:0] p_req, p_busy, p_eof, p_done, p_pending;

    // Control word decoder
    dsp_ctl_decode #(
        .CTL_W(CTL_W), .RXSTOP_BIT(RXSTOP_BIT),
        .TXSTOP_BIT(TXSTOP_BIT), .NOPOLL_BIT(NOPOLL_BIT)
    ) u_dec (
        .clk(clk), .rst_n(rst_n), .wr(ctl_wr), .wdata(ctl_wdata),
        .rx_req(rx_req), .tx_req(tx_req), .restart(restart), .cfg_q(cfg_q)
    );

    // Gather per-direction inputs into vectors
    always_comb begin
        p_req[PATH_RX]  = rx_req;
        p_req[PATH_TX]  = tx_req;
        p_busy[PATH_RX] = rx_busy;
        p_busy[PATH_TX] = tx_busy;
        p_eof[PATH_RX]  = rx_eof;
        p_eof[PATH_TX]  = tx_eof;
    end

    // One stop tracker per direction
    for (genvar g = 0; g < N_PATHS; g++) begin : g_path
        dsp_stop_track u_trk (
            .clk(clk), .rst_n(rst_n), .req(p_req[g]), .busy(p_busy[g]),
            .eof(p_eof[g]), .done(p_done[g]), .pending(p_pending[g])
        );
    end

    assign rx_stop_done = p_done[PATH_RX];
    assign tx_stop_done = p_done[PATH_TX];

    // Ring-0 poll timer
    dsp_poll_timer #(.PERIOD(PERIOD)) u_tmr (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .no_poll(cfg_q.no_poll), .tx_stop(cfg_q.tx_stop), .poll(ring0_poll)
    );

endmodule

// File: rtl/dsp_checker.sv
// Port-level properties of the graceful stop and poll controller.
// Assumes: attached by the bind statement at the end of this file.
module dsp_checker #(
    parameter int unsigned CTL_W      = 32,
    parameter int unsigned RXSTOP_BIT = 4,
    parameter int unsigned TXSTOP_BIT = 3,
    parameter int unsigned NOPOLL_BIT = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctl_wr,
    input logic [CTL_W-1:0] ctl_wdata,
    input logic             rx_busy,
    input logic             rx_eof,
    input logic             tx_busy,
    input logic             tx_eof,
    input logic             rx_stop_done,
    input logic             tx_stop_done,
    input logic             ring0_poll
);

    logic sh_txstop, sh_nopoll;

    // Shadow of the last written timer fields, seen from the ports
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_txstop <= 1'b0;
            sh_nopoll <= 1'b0;
        end else if (ctl_wr) begin
            sh_txstop <= ctl_wdata[TXSTOP_BIT];
            sh_nopoll <= ctl_wdata[NOPOLL_BIT];
        end
    end

    // R1
    rx_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr && ctl_wdata[RXSTOP_BIT] && !rx_busy |=> rx_stop_done);

    // R2
    rx_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_stop_done |-> ($past(rx_eof) ||
                          $past(ctl_wr && ctl_wdata[RXSTOP_BIT] && !rx_busy)));

    // R3
    tx_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr && ctl_wdata[TXSTOP_BIT] && !tx_busy |=> tx_stop_done);

    // R4
    tx_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_stop_done |-> ($past(tx_eof) ||
                          $past(ctl_wr && ctl_wdata[TXSTOP_BIT] && !tx_busy)));

    // R5
    restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr && !ctl_wdata[NOPOLL_BIT] |=> !ring0_poll);

    // R6
    poll_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ring0_poll |=> !ring0_poll);

    // R7
    poll_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ring0_poll |-> !$past(sh_txstop));

    // R8
    poll_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ring0_poll |-> !$past(sh_nopoll));

    // R9
    reset_low_chk: assert property (@(posedge clk)
        !rst_n |=> (!rx_stop_done && !tx_stop_done && !ring0_poll));

endmodule

bind dma_stop_poll_ctrl dsp_checker #(
    .CTL_W(CTL_W), .RXSTOP_BIT(RXSTOP_BIT),
    .TXSTOP_BIT(TXSTOP_BIT), .NOPOLL_BIT(NOPOLL_BIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .rx_busy(rx_busy), .rx_eof(rx_eof), .tx_busy(tx_busy), .tx_eof(tx_eof),
    .rx_stop_done(rx_stop_done), .tx_stop_done(tx_stop_done),
    .ring0_poll(ring0_poll)
);

// File: tb/dma_stop_poll_ctrl_test.sv
// Scoreboard bench: stimulus tasks schedule expected pulses by cycle,
// and a monitor compares the three outputs every cycle.
module dma_stop_poll_ctrl_test;

    localparam int P = 8;  // 800 Hz clock model / 100 Hz poll

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 1'b0;
    logic [31:0] ctl_wdata = '0;
    logic        rx_busy = 1'b0, rx_eof = 1'b0, tx_busy = 1'b0, tx_eof = 1'b0;
    logic        rx_stop_done, tx_stop_done, ring0_poll;

    dma_stop_poll_ctrl #(.CLK_HZ(800), .POLL_HZ(100)) uut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .rx_busy(rx_busy), .rx_eof(rx_eof), .tx_busy(tx_busy), .tx_eof(tx_eof),
        .rx_stop_done(rx_stop_done), .tx_stop_done(tx_stop_done),
        .ring0_poll(ring0_poll)
    );

    always #5 clk = ~clk;

    typedef struct {
        int         cyc;
        logic [2:0] bits;   // [2] rx done, [1] tx done, [0] poll
        string      req;
    } exp_t;

    exp_t  q[$];
    int    cyc = 0;
    int    n_chk = 0, n_bad = 0;
    bit    mon_on = 1'b0, finished = 1'b0;
    string cur_req = "R9";

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req,
                         input logic [2:0] act, input logic [2:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s cycle %0d act=%b exp=%b", req, cyc, act, exp);
        end
    endtask

    task automatic expect_at(input int c, input logic [2:0] b, input string r);
        exp_t e;
        e.cyc = c; e.bits = b; e.req = r;
        q.push_back(e);
    endtask

    // Monitor: pops items due now and compares with the outputs
    always @(negedge clk) begin
        if (mon_on && rst_n) begin
            logic [2:0] ex, ob;
            string tag;
            ex = '0; tag = cur_req;
            for (int i = q.size() - 1; i >= 0; i--) begin
                if (q[i].cyc == cyc) begin
                    ex |= q[i].bits; tag = q[i].req; q.delete(i);
                end else if (q[i].cyc < cyc) begin
                    check(1'b0, q[i].req, 3'b000, q[i].bits); q.delete(i);
                end
            end
            ob = {rx_stop_done, tx_stop_done, ring0_poll};
            if (ex != 3'b000 || ob != 3'b000) check(ob == ex, tag, ob, ex);
        end
    end

    task automatic ctl_write(input logic [31:0] d, output int at);
        @(negedge clk);
        ctl_wr = 1'b1; ctl_wdata = d; at = cyc;
        @(negedge clk);
        ctl_wr = 1'b0; ctl_wdata = '0;
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    initial begin
        int a, b;
        repeat (3) @(negedge clk);
        // R9: outputs low while reset is held
        check({rx_stop_done, tx_stop_done, ring0_poll} == 3'b000, "R9",
              {rx_stop_done, tx_stop_done, ring0_poll}, 3'b000);
        rst_n = 1'b1;
        mon_on = 1'b1;
        repeat (3 * P) @(negedge clk);
        // R9: timer idle after reset, nothing pulses without a write
        check({rx_stop_done, tx_stop_done, ring0_poll} == 3'b000, "R9",
              {rx_stop_done, tx_stop_done, ring0_poll}, 3'b000);

        // R1: receive stop with idle path (polling disabled)
        cur_req = "R1";
        ctl_write(32'h50, a); expect_at(a + 1, 3'b100, "R1");
        repeat (4) @(negedge clk);
        // R3: transmit stop with idle path
        cur_req = "R3";
        ctl_write(32'h48, a); expect_at(a + 1, 3'b010, "R3");
        repeat (4) @(negedge clk);
        // R3: both stop bits together
        ctl_write(32'h58, a); expect_at(a + 1, 3'b110, "R3");
        repeat (4) @(negedge clk);

        // R2: deferred receive stop
        cur_req = "R2";
        rx_busy = 1'b1;
        ctl_write(32'h50, a);
        repeat (6) @(negedge clk);
        rx_eof = 1'b1; a = cyc; expect_at(a + 1, 3'b100, "R2");
        @(negedge clk); rx_eof = 1'b0; rx_busy = 1'b0;
        repeat (4) @(negedge clk);
        rx_eof = 1'b1;                      // nothing pending: no pulse
        @(negedge clk); rx_eof = 1'b0;
        repeat (4) @(negedge clk);

        // R4: deferred transmit stop
        cur_req = "R4";
        tx_busy = 1'b1;
        ctl_write(32'h48, a);
        repeat (5) @(negedge clk);
        tx_eof = 1'b1; a = cyc; expect_at(a + 1, 3'b010, "R4");
        @(negedge clk); tx_eof = 1'b0; tx_busy = 1'b0;
        repeat (3) @(negedge clk);
        tx_eof = 1'b1;
        @(negedge clk); tx_eof = 1'b0;
        repeat (4) @(negedge clk);

        // R5 and R6: start polling, three periods
        cur_req = "R6";
        ctl_write(32'h00, a);
        expect_at(a + 1 + P, 3'b001, "R5");
        expect_at(a + 1 + 2 * P, 3'b001, "R6");
        expect_at(a + 1 + 3 * P, 3'b001, "R6");
        wait_until(a + 2 + 3 * P);
        // R8: disable polling, no further pulses
        cur_req = "R8";
        ctl_write(32'h40, b);
        repeat (4 * P) @(negedge clk);

        // R5: restart in the middle of a period
        cur_req = "R5";
        ctl_write(32'h00, a);
        repeat (2) @(negedge clk);
        ctl_write(32'h00, b);
        expect_at(b + 1 + P, 3'b001, "R5");
        expect_at(b + 1 + 2 * P, 3'b001, "R6");
        wait_until(b + 2 + 2 * P);
        cur_req = "R8";
        ctl_write(32'h40, a);
        repeat (3 * P) @(negedge clk);

        // R7: transmit stop suppresses polls, timer keeps going
        cur_req = "R7";
        ctl_write(32'h08, a); expect_at(a + 1, 3'b010, "R3");
        repeat (4 * P) @(negedge clk);
        ctl_write(32'h00, b);
        expect_at(b + 1 + P, 3'b001, "R7");
        expect_at(b + 1 + 2 * P, 3'b001, "R7");
        wait_until(b + 2 + 2 * P);
        cur_req = "R8";
        ctl_write(32'h40, a);
        repeat (3 * P) @(negedge clk);

        mon_on = 1'b0;
        foreach (q[i]) check(1'b0, q[i].req, 3'b000, q[i].bits);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule